// File: doc/BRIEF.md
# Digital-ramp converter controller

This block is the digital half of a ramp-type analogue-to-digital converter. It drives an N-bit code into an external DAC and reads one external comparator bit, `cmp_above`, which is high while the analogue input is above the DAC output. From these two signals it works out a digital value for the input. It publishes that value on a registered result port together with a valid flag.

A single mode input selects one of two behaviours. In counting mode, every conversion starts at code zero and climbs one step per clock. It stops when the comparator reports that the DAC has reached or passed the input. The code reached is then stored and the next conversion starts from zero at once. In tracking mode, an up/down counter moves one step toward the input on every clock and is never cleared, so the result follows a slowly changing input. Any change of the mode input returns the counter to zero and starts the selected process from the beginning.

Top module: `ramp_adc`

## Requirements
- R1: While `rst` is high, at the clock edge, `dac_code` is 0, `result` is 0 and `valid` is 0.
- R2: Every counting-mode conversion begins with `dac_code` equal to 0: after reset, after a mode change and in the cycle after each stored result.
- R3: In counting mode (`mode` = 0), `dac_code` rises by exactly one per clock while `cmp_above` is 1 and `dac_code` is below all ones. The time between two stored results is therefore v+1 clocks for an input level v of 255 or less.
- R4: In counting mode, a clock edge with `cmp_above` = 0 copies `dac_code` into `result` and raises `valid` for exactly one cycle, and `dac_code` returns to 0 in that same cycle. The stored value is the smallest code at which the DAC output is not below the input.
- R5: In counting mode, if `cmp_above` is still 1 when `dac_code` is all ones, all ones is stored. A conversion therefore never takes more than 2^N clocks.
- R6: In tracking mode (`mode` = 1), `dac_code` rises by one on each clock when `cmp_above` is 1 and falls by one when it is 0. It is never cleared while the mode stays the same.
- R7: In tracking mode, `dac_code` saturates: it stays at all ones when asked to rise and stays at 0 when asked to fall.
- R8: In tracking mode, `result` takes the value `dac_code` had in the previous cycle, on every clock. `valid` stays 1 from the second tracking cycle on.
- R9: A clock edge at which `mode` differs from the mode in use sets `dac_code`, `result` and `valid` to 0. The new mode's process then starts from code 0 on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | 0 selects counting from zero, 1 selects up/down tracking |
| cmp_above | input | 1 | Comparator: 1 while the input is above the DAC output |
| dac_code | output | WIDTH | Code driven to the external DAC |
| result | output | WIDTH | Registered conversion value |
| valid | output | 1 | One-cycle pulse per result in counting mode; held high in tracking mode |

## Verification
The bench models a DAC and a comparator around the block and runs a behavioural reference next to it that is compared on every clock. It drives an input level of zero, where a design that compared in the wrong direction would store 1 or ramp forever. It also drives a level above full scale, where a counter that wrapped would restart at zero and never store all ones. In tracking mode it pushes the input beyond both rails, where a wrapping counter would jump from 255 to 0 or from 0 to 255. It drops the input from one level to another, where a design that cleared the counter would restart its climb from zero. Mode changes arrive in the middle of a conversion and in the middle of tracking, where a design that kept the old count would publish a stale result or carry a partly climbed code into the new mode.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

    typedef enum logic {
        MODE_COUNT = 1'b0,
        MODE_TRACK = 1'b1
    } conv_mode_e;

    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_CLEAR = 2'd1,
        CNT_UP    = 2'd2,
        CNT_DOWN  = 2'd3
    } cnt_op_e;

    typedef enum logic [1:0] {
        RES_IDLE  = 2'd0,
        RES_CLEAR = 2'd1,
        RES_LOAD  = 2'd2
    } res_op_e;

    typedef struct packed {
        cnt_op_e cnt_op;
        res_op_e res_op;
    } step_cmd_t;

    // A step that would cross a rail is dropped.
    function automatic logic step_blocked(cnt_op_e op, logic at_zero, logic at_max);
        return ((op == CNT_UP) && at_max) || ((op == CNT_DOWN) && at_zero);
    endfunction

endpackage

// File: rtl/ramp_step_ctrl.sv
module ramp_step_ctrl
    import ramp_adc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  conv_mode_e mode_req,
    input  logic       cmp_above,
    input  logic       code_at_max,
    output step_cmd_t  cmd,
    output conv_mode_e mode_now
);

    conv_mode_e mode_q;
    logic       mode_switch;

    assign mode_switch = (mode_req != mode_q);
    assign mode_now    = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= mode_req;
        end else begin
            mode_q <= mode_req;
        end
    end

    always_comb begin
        cmd.cnt_op = CNT_HOLD;
        cmd.res_op = RES_IDLE;
        if (mode_switch) begin
            cmd.cnt_op = CNT_CLEAR;
            cmd.res_op = RES_CLEAR;
        end else if (mode_q == MODE_COUNT) begin
            if (cmp_above && !code_at_max) begin
                cmd.cnt_op = CNT_UP;
                cmd.res_op = RES_IDLE;
            end else begin
                cmd.cnt_op = CNT_CLEAR;
                cmd.res_op = RES_LOAD;
            end
        end else begin
            cmd.cnt_op = cmp_above ? CNT_UP : CNT_DOWN;
            cmd.res_op = RES_LOAD;
        end
    end

endmodule

// File: rtl/ramp_code_counter.sv
module ramp_code_counter
    import ramp_adc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          op,
    output logic [WIDTH-1:0] code,
    output logic             at_zero,
    output logic             at_max
);

    localparam logic [WIDTH-1:0] CODE_MAX  = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] CODE_ZERO = '0;
    localparam logic [WIDTH-1:0] CODE_ONE  = WIDTH'(1);

    logic [WIDTH-1:0] code_q;

    assign code    = code_q;
    assign at_zero = (code_q == CODE_ZERO);
    assign at_max  = (code_q == CODE_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= CODE_ZERO;
        end else if (!step_blocked(op, at_zero, at_max)) begin
            case (op)
                CNT_CLEAR: code_q <= CODE_ZERO;
                CNT_UP:    code_q <= code_q + CODE_ONE;
                CNT_DOWN:  code_q <= code_q - CODE_ONE;
                default:   code_q <= code_q;
            endcase
        end
    end

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (op == CNT_UP && code_q != CODE_MAX) |=> code_q == $past(code_q) + CODE_ONE);

    // R7
    no_wrap_high_chk: assert property (@(posedge clk) disable iff (rst)
        (op == CNT_UP && code_q == CODE_MAX) |=> code_q == CODE_MAX);

    // R7
    no_wrap_low_chk: assert property (@(posedge clk) disable iff (rst)
        (op == CNT_DOWN && code_q == CODE_ZERO) |=> code_q == CODE_ZERO);

endmodule

// File: rtl/ramp_result_reg.sv
module ramp_result_reg
    import ramp_adc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  res_op_e          op,
    input  logic [WIDTH-1:0] code_in,
    output logic [WIDTH-1:0] result,
    output logic             valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            valid  <= 1'b0;
        end else begin
            case (op)
                RES_LOAD: begin
                    result <= code_in;
                    valid  <= 1'b1;
                end
                RES_CLEAR: begin
                    result <= '0;
                    valid  <= 1'b0;
                end
                default: begin
                    valid  <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ramp_adc.sv
module ramp_adc
    import ramp_adc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode,
    input  logic             cmp_above,
    output logic [WIDTH-1:0] dac_code,
    output logic [WIDTH-1:0] result,
    output logic             valid
);

    localparam logic [WIDTH-1:0] CODE_MAX = {WIDTH{1'b1}};

    step_cmd_t  cmd;
    conv_mode_e mode_now;
    logic       at_zero;
    logic       at_max;

    ramp_step_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .mode_req    (conv_mode_e'(mode)),
        .cmp_above   (cmp_above),
        .code_at_max (at_max),
        .cmd         (cmd),
        .mode_now    (mode_now)
    );

    ramp_code_counter #(.WIDTH(WIDTH)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .op      (cmd.cnt_op),
        .code    (dac_code),
        .at_zero (at_zero),
        .at_max  (at_max)
    );

    ramp_result_reg #(.WIDTH(WIDTH)) u_result (
        .clk     (clk),
        .rst     (rst),
        .op      (cmd.res_op),
        .code_in (dac_code),
        .result  (result),
        .valid   (valid)
    );

    // R4
    store_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && mode_now == MODE_COUNT) |-> dac_code == '0);

    // R9
    mode_switch_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != mode_now) |=> (dac_code == '0 && result == '0 && !valid));

    // R8
    track_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_now == MODE_TRACK && mode) |=> (valid && result == $past(dac_code)));

    // R6
    track_down_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_now == MODE_TRACK && mode && !cmp_above && !at_zero)
            |=> dac_code == $past(dac_code) - WIDTH'(1));

    // R5
    full_scale_store_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_now == MODE_COUNT && !mode && cmp_above && dac_code == CODE_MAX)
            |=> (valid && result == CODE_MAX));

endmodule

// File: tb/ramp_adc_test.sv
module ramp_adc_test;

    localparam int W    = 8;
    localparam int CMAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode = 1'b0;
    logic         cmp_above;
    logic [W-1:0] dac_code;
    logic [W-1:0] result;
    logic         valid;

    int vin = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference state
    int m_cnt = 0;
    int m_res = 0;
    int m_val = 0;
    int m_mode = 0;

    always #2 clk = ~clk;

    // external DAC and comparator
    assign cmp_above = (vin > int'(dac_code));

    ramp_adc #(.WIDTH(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .cmp_above (cmp_above),
        .dac_code  (dac_code),
        .result    (result),
        .valid     (valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit up;
        up = (vin > m_cnt);
        if (rst) begin
            m_cnt = 0; m_res = 0; m_val = 0; m_mode = int'(mode);
        end else if (int'(mode) != m_mode) begin
            m_mode = int'(mode);
            m_cnt = 0; m_res = 0; m_val = 0;
        end else if (m_mode == 0) begin
            if (up && m_cnt < CMAX) begin
                m_cnt = m_cnt + 1;
                m_val = 0;
            end else begin
                m_res = m_cnt;
                m_val = 1;
                m_cnt = 0;
            end
        end else begin
            m_res = m_cnt;
            m_val = 1;
            if (up) begin
                if (m_cnt < CMAX) m_cnt = m_cnt + 1;
            end else begin
                if (m_cnt > 0) m_cnt = m_cnt - 1;
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (m_mode == 0) begin
            chk(int'(dac_code) == m_cnt, "R3 counting code", int'(dac_code), m_cnt);
            chk(int'(result) == m_res, "R4 counting result", int'(result), m_res);
            chk(int'(valid) == m_val, "R4 counting valid", int'(valid), m_val);
        end else begin
            chk(int'(dac_code) == m_cnt, "R6 tracking code", int'(dac_code), m_cnt);
            chk(int'(result) == m_res, "R8 tracking result", int'(result), m_res);
            chk(int'(valid) == m_val, "R8 tracking valid", int'(valid), m_val);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wait_valid(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!valid && n < 600);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic count_level(input int lvl, input int exp_res, input int exp_len, input string tag);
        int n;
        vin = lvl;
        wait_valid(n);
        wait_valid(n);
        chk(int'(result) == exp_res, tag, int'(result), exp_res);
        chk(n == exp_len, tag, n, exp_len);
        // R2: next conversion starts at zero
        chk(dac_code == '0, "R2 restart at zero", int'(dac_code), 0);
    endtask

    initial begin
        int n;
        rst = 1'b1;
        mode = 1'b0;
        vin = 0;
        step();
        step();
        // R1
        chk(dac_code == '0, "R1 reset code", int'(dac_code), 0);
        chk(result == '0, "R1 reset result", int'(result), 0);
        chk(valid == 1'b0, "R1 reset valid", int'(valid), 0);
        rst = 1'b0;

        // counting mode conversions
        count_level(37, 37, 38, "R3 level 37");
        count_level(0, 0, 1, "R4 level zero");
        count_level(1, 1, 2, "R4 level one");
        count_level(200, 200, 201, "R3 level 200");
        count_level(255, 255, 256, "R5 level full");
        count_level(256, CMAX, 256, "R5 above full scale");
        // input change mid-conversion
        vin = 90;
        run(40);
        vin = 10;
        wait_valid(n);
        wait_valid(n);
        chk(int'(result) == 10, "R4 level after change", int'(result), 10);

        // switch to tracking mid-conversion
        vin = 100;
        run(30);
        mode = 1'b1;
        step();
        // R9
        chk(dac_code == '0, "R9 switch code", int'(dac_code), 0);
        chk(result == '0, "R9 switch result", int'(result), 0);
        chk(valid == 1'b0, "R9 switch valid", int'(valid), 0);
        step();
        chk(int'(dac_code) == 1, "R9 restart from zero", int'(dac_code), 1);
        run(130);
        chk(dac_code == 8'd99 || dac_code == 8'd100, "R6 settled near level",
            int'(dac_code), 100);
        // drop input: counter must not clear
        vin = 90;
        step();
        chk(int'(dac_code) >= 98, "R6 never cleared", int'(dac_code), 98);
        run(30);
        chk(dac_code == 8'd89 || dac_code == 8'd90, "R6 follows drop",
            int'(dac_code), 90);
        // rails
        vin = 400;
        run(200);
        chk(int'(dac_code) == CMAX, "R7 top rail", int'(dac_code), CMAX);
        run(5);
        chk(int'(dac_code) == CMAX, "R7 holds top rail", int'(dac_code), CMAX);
        chk(valid == 1'b1, "R8 valid held", int'(valid), 1);
        vin = 0;
        run(300);
        chk(dac_code == '0, "R7 bottom rail", int'(dac_code), 0);
        run(5);
        chk(dac_code == '0, "R7 holds bottom rail", int'(dac_code), 0);

        // back to counting mid-track
        vin = 60;
        run(20);
        mode = 1'b0;
        step();
        chk(dac_code == '0, "R9 back to counting", int'(dac_code), 0);
        chk(valid == 1'b0, "R9 back valid", int'(valid), 0);
        wait_valid(n);
        chk(int'(result) == 60, "R2 first conversion after switch", int'(result), 60);
        chk(n == 61, "R2 first conversion length", n, 61);

        // reset in the middle of tracking
        mode = 1'b1;
        run(40);
        rst = 1'b1;
        step();
        chk(dac_code == '0, "R1 mid-run reset", int'(dac_code), 0);
        chk(valid == 1'b0, "R1 mid-run reset valid", int'(valid), 0);
        rst = 1'b0;
        run(20);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule